// File: doc/BRIEF.md
# Chopped Converter Pair Averager

This block follows the decimation filter of a chopped delta-sigma converter. The converter swaps its modulator inputs on every conversion, so each filter word holds the wanted signal plus an offset term whose sign flips from one word to the next. The block drives the polarity control for that swap. It also adds each incoming filter word to the word that came just before it and halves the sum. The two offset terms have opposite signs, so they cancel in that sum.

The first usable result appears once two words have arrived after reset or a restart. After that, every accepted word produces one result. The output rate therefore equals the filter update rate. A ready flag tells the reader that a result is waiting, and reading the result clears the flag.

`rst_n` is asynchronous and active low. Its release must be synchronous to `clk`.

Top module: `chop_avg`

## Requirements
- R1: While `rst_n` is low and after its release, `chop_phase`, `avg_valid` and `ready` are 0 and `avg_out` is 0.
- R2: `chop_phase` inverts at every clock edge where `word_valid` is 1 and `restart` is 0, and holds its value otherwise. The first word after reset or restart is taken with `chop_phase` = 0.
- R3: The first word accepted after reset or restart produces no `avg_valid` pulse. The second accepted word produces one.
- R4: At the edge that accepts a word and has a stored previous word, `avg_out` becomes floor((current + previous) / 2) and `avg_valid` is 1 for that one cycle. Both words are two's complement, and the sum is formed one bit wider than `DW` and shifted arithmetically.
- R5: Once the first pair has been filled, every accepted word gives exactly one result, formed with the word immediately before it. Pairs overlap.
- R6: `restart` = 1 discards the stored word and sets `chop_phase` to 0, `avg_valid` to 0 and `ready` to 0. A word presented in the same cycle is ignored, and `avg_out` keeps its value.
- R7: `ready` goes to 1 with each result and stays there until a cycle with `rd` = 1. If `rd` and a new result coincide, `ready` stays 1.
- R8: In cycles without an accepted word, `avg_valid` is 0 and `avg_out` holds.
- R9: Averaging full-scale values does not wrap. max with max gives max, and min with min gives min.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Clears the pair store and the chop phase |
| word_valid | input | 1 | Strobe marking a new filter word |
| word_in | input | DW | Signed filter word |
| rd | input | 1 | Result read strobe, clears `ready` |
| chop_phase | output | 1 | Input swap control, 0 = not inverted |
| avg_out | output | DW | Signed averaged result |
| avg_valid | output | 1 | One-cycle pulse marking a new result |
| ready | output | 1 | Result-waiting flag |

## Verification
Every output of this block is registered once. A word, restart or read that is driven before a rising edge is therefore visible on `chop_phase`, `avg_valid`, `avg_out` and `ready` just after that same edge, and no result arrives later. The bench drives inputs on the falling edge and samples one time unit after the following rising edge. As a result, each check looks at exactly the edge that should have acted on the stimulus. Idle cycles are checked the same way, so that a late or repeated pulse would show up as a miscompare.

// File: rtl/chop_avg_pkg.sv
package chop_avg_pkg;
  // fill level of the pair store since reset or restart
  typedef enum logic [1:0] {
    FILL_EMPTY = 2'd0,
    FILL_ONE   = 2'd1,
    FILL_FULL  = 2'd2
  } fill_e;
endpackage

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic accept,
  output logic phase
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (restart)     phase_d = 1'b0;
    else if (accept) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  AST_CHOP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !restart) |=> (phase_q != $past(phase_q))); // R2
  AST_CHOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !restart) |=> $stable(phase_q)); // R2
endmodule

// File: rtl/chop_pair_store.sv
module chop_pair_store #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          accept,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] prev_word,
  output logic          pair_ok
);
  import chop_avg_pkg::*;

  fill_e         fill_q, fill_d;
  logic [DW-1:0] prev_q, prev_d;
  logic          prev_en;

  always_comb begin
    fill_d  = fill_q;
    prev_en = accept && !restart;
    prev_d  = word_in;
    if (restart) begin
      fill_d = FILL_EMPTY;
    end else if (accept) begin
      case (fill_q)
        FILL_EMPTY: fill_d = FILL_ONE;
        default:    fill_d = FILL_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= FILL_EMPTY;
    else        fill_q <= fill_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  assign prev_word = prev_q;
  assign pair_ok   = (fill_q != FILL_EMPTY);

  AST_STORE_EMPTY_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !pair_ok); // R6
  AST_STORE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !restart) |=> pair_ok); // R3
endmodule

// File: rtl/chop_avg_core.sv
module chop_avg_core #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] cur_word,
  input  logic [DW-1:0] prev_word,
  output logic [DW-1:0] avg,
  output logic          avg_vld
);
  localparam int SW = DW + 1;

  logic signed [SW-1:0] sum_w;
  logic [DW-1:0]        avg_q, avg_d;
  logic                 vld_q, vld_d;

  always_comb begin
    sum_w = $signed({cur_word[DW-1], cur_word}) + $signed({prev_word[DW-1], prev_word});
    avg_d = sum_w[SW-1:1];
    vld_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    avg_q <= '0;
    else if (fire) avg_q <= avg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign avg     = avg_q;
  assign avg_vld = vld_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_vld |-> $stable(avg_q)); // R8
  AST_AVG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (($signed(avg_q) >= $signed($past(cur_word)) && $signed(avg_q) <= $signed($past(prev_word)))
           || ($signed(avg_q) >= $signed($past(prev_word)) && $signed(avg_q) <= $signed($past(cur_word))))); // R9
endmodule

// File: rtl/chop_avg.sv
module chop_avg #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          word_valid,
  input  logic [DW-1:0] word_in,
  input  logic          rd,
  output logic          chop_phase,
  output logic [DW-1:0] avg_out,
  output logic          avg_valid,
  output logic          ready
);
  logic          accept;
  logic          fire;
  logic          pair_ok;
  logic [DW-1:0] prev_word;
  logic          rdy_q, rdy_d;

  assign accept = word_valid && !restart;
  assign fire   = accept && pair_ok;

  chop_phase_ctrl u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .accept  (accept),
    .phase   (chop_phase)
  );

  chop_pair_store #(.DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .accept    (accept),
    .word_in   (word_in),
    .prev_word (prev_word),
    .pair_ok   (pair_ok)
  );

  chop_avg_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .cur_word  (word_in),
    .prev_word (prev_word),
    .avg       (avg_out),
    .avg_vld   (avg_valid)
  );

  always_comb begin
    rdy_d = rdy_q;
    if (restart)   rdy_d = 1'b0;
    else if (fire) rdy_d = 1'b1;
    else if (rd)   rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign ready = rdy_q;

  AST_FIRST_WORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pair_ok) |=> !avg_valid); // R3
  AST_VALID_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> ($past(word_valid) && !$past(restart))); // R8
  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> ready); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!chop_phase && !avg_valid && !ready)); // R6
endmodule

// File: tb/chop_avg_bench.sv
module chop_avg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int NV = 12;

  typedef struct packed {
    logic signed [DW-1:0] w;
    logic                 v;
    logic signed [DW-1:0] a;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{ 24'sd100,      1'b0,  24'sd0       },
    '{ 24'sd300,      1'b1,  24'sd200     },
    '{-24'sd300,      1'b1,  24'sd0       },
    '{-24'sd301,      1'b1, -24'sd301     },
    '{ 24'sd0,        1'b1, -24'sd151     },
    '{ 24'sd7,        1'b1,  24'sd3       },
    '{-24'sd1,        1'b1,  24'sd3       },
    '{ 24'sd8388607,  1'b1,  24'sd4194303 },
    '{ 24'sd8388607,  1'b1,  24'sd8388607 },
    '{-24'sd8388608,  1'b1, -24'sd1       },
    '{-24'sd8388608,  1'b1, -24'sd8388608 },
    '{ 24'sd5,        1'b1, -24'sd4194302 }
  };

  logic          clk;
  logic          rst_n;
  logic          restart;
  logic          word_valid;
  logic [DW-1:0] word_in;
  logic          rd;
  logic          chop_phase;
  logic [DW-1:0] avg_out;
  logic          avg_valid;
  logic          ready;

  int  n_chk;
  int  n_fail;
  bit  done;

  chop_avg #(.DW(DW)) u_chop_avg (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .word_valid (word_valid),
    .word_in    (word_in),
    .rd         (rd),
    .chop_phase (chop_phase),
    .avg_out    (avg_out),
    .avg_valid  (avg_valid),
    .ready      (ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; restart = 1'b0; word_valid = 1'b0; word_in = '0; rd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1 chop in reset", chop_phase, 0);
    check("R1 ready in reset", ready, 0);
    @(negedge clk) rst_n = 1'b1;
    step();
    check("R1 valid after release", avg_valid, 0);
    check("R1 out after release", $signed(avg_out), 0);
    check("R1 chop after release", chop_phase, 0);

    // table walk: R2 R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      word_valid = 1'b1;
      word_in    = VEC[i].w;
      step();
      check(i < 2 ? "R3 valid on fill" : "R5 valid per word", avg_valid, VEC[i].v);
      if (VEC[i].v)
        check(i >= 7 ? "R9 average full scale" : "R4 average value", $signed(avg_out), VEC[i].a);
      check("R2 chop phase", chop_phase, (i + 1) % 2);
    end
    @(negedge clk) word_valid = 1'b0;

    // R8 idle: no pulse, output and phase hold
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8 no valid when idle", avg_valid, 0);
      check("R8 output held", $signed(avg_out), -4194302);
      check("R2 chop held when idle", chop_phase, 0);
    end

    // R7 ready flag
    check("R7 ready waiting", ready, 1);
    @(negedge clk) rd = 1'b1;
    step();
    check("R7 ready cleared by rd", ready, 0);
    @(negedge clk) begin rd = 1'b1; word_valid = 1'b1; word_in = 24'sd9; end
    step();
    check("R7 set wins over rd", ready, 1);
    check("R4 average after read", $signed(avg_out), 7);
    @(negedge clk) begin rd = 1'b0; word_valid = 1'b0; end
    step();
    check("R7 ready held without rd", ready, 1);

    // R6 restart with a coincident word
    @(negedge clk) begin restart = 1'b1; word_valid = 1'b1; word_in = 24'sd1000; end
    step();
    check("R6 chop cleared", chop_phase, 0);
    check("R6 valid low", avg_valid, 0);
    check("R6 ready cleared", ready, 0);
    check("R6 output kept", $signed(avg_out), 7);
    @(negedge clk) begin restart = 1'b0; word_in = 24'sd40; end
    step();
    check("R3 no result on first word after restart", avg_valid, 0);
    check("R2 chop after first word", chop_phase, 1);
    @(negedge clk) word_in = 24'sd60;
    step();
    check("R6 coincident word ignored valid", avg_valid, 1);
    check("R6 coincident word ignored value", $signed(avg_out), 50);
    @(negedge clk) word_valid = 1'b0;

    // R1 asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 async reset ready", ready, 0);
    check("R1 async reset out", $signed(avg_out), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule